// File: doc/BRIEF.md
# Debugger-to-Processor Receive Mailbox

This block is a one-word holding register that passes data from an external debugger to the processor. The debugger side presents a word on a valid/ready write channel. The word is latched on the clock edge where valid is high. The processor side issues a one-cycle read strobe. One cycle later it receives the word on a registered read channel marked by a valid pulse. A single full flag shows whether an unread word is present. That flag is visible to both sides, and each side uses it as its handshake: the debugger waits for the flag to go low before writing, and the processor polls it before reading.

Reads are destructive. Every read strobe empties the mailbox, whether or not it held data. A read of an empty mailbox does not stall and does not signal an error. It returns a fixed filler word with no defined meaning. The write channel applies no back-pressure: ready is tied high, and a write to a full mailbox replaces the held word and flags an overrun. When a write and a read land in the same cycle, the read takes the old word and the mailbox ends up full with the new word. The data register has no reset value.

Top module: `dbg_rx_mailbox`

## Requirements
- R1: After reset, `rx_full`, `cpu_rd_valid` and `wr_overrun` are all 0.
- R2: `dbg_wr_ready` is always 1. A cycle with `dbg_wr_valid` = 1 latches `dbg_wr_data`, and `rx_full` reads 1 after that clock edge.
- R3: A read strobe while `rx_full` is 1 returns the most recently written word on `cpu_rd_data` in the cycle after the strobe, with `cpu_rd_valid` = 1 in that cycle.
- R4: A read strobe without a simultaneous write leaves `rx_full` at 0 after the edge, whatever its previous value.
- R5: A read strobe while `rx_full` is 0 still produces a one-cycle `cpu_rd_valid` pulse in the next cycle, and `rx_full` stays 0. The data value in that cycle is unspecified.
- R6: When a write and a read strobe occur in the same cycle, the read returns the word held before that edge (if `rx_full` was 1), `rx_full` is 1 after the edge, and a following read returns the new word.
- R7: A write while `rx_full` is 1 and no read strobe is active replaces the held word and raises `wr_overrun` for exactly the following cycle. `wr_overrun` is 0 in every other case.
- R8: `cpu_rd_valid` is 1 only in the cycle directly after a read strobe.
- R9: `rx_full` changes only on a write or a read strobe; when neither is active, it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| dbg_wr_valid | input | 1 | Debugger write request |
| dbg_wr_ready | output | 1 | Write accept, always 1 |
| dbg_wr_data | input | DW | Word from the debugger |
| cpu_rd_req | input | 1 | Processor read strobe (destructive) |
| cpu_rd_valid | output | 1 | Read result valid, one cycle after the strobe |
| cpu_rd_data | output | DW | Read result word |
| rx_full | output | 1 | Mailbox holds an unread word |
| wr_overrun | output | 1 | One-cycle pulse after a write replaced unread data |

## Verification
The hardest case to reach from the ports is a write and a read in the same cycle while the mailbox is already full. In that cycle the old word must come out, the new word must stay held, and no overrun may be flagged. The bench runs every sequence of four cycles over the four combinations of write and read strobe, with a reset before each sequence. Each sequence therefore reaches that case from every possible prior state. A cycle-level model in the bench, fed with an arithmetic data pattern, predicts the flag, the pulses and the returned words.

// File: rtl/dbg_rx_pkg.sv
package dbg_rx_pkg;
  localparam int unsigned DEF_DW = 32;

  // Classification of the access seen in one cycle
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_READ  = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_e;

  function automatic acc_e classify(input logic wr, input logic rd);
    return acc_e'({rd, wr});
  endfunction
endpackage

// File: rtl/drx_store.sv
module drx_store #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  // No reset on the data word: its contents are undefined after reset
  always_ff @(posedge clk) begin
    if (load) q <= din;
  end

  AST_STORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(din)) else $error("store load"); // R2
endmodule

// File: rtl/drx_flag.sv
module drx_flag
  import dbg_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic rd,
  output logic full,
  output logic overrun
);
  acc_e acc;
  logic full_d;
  logic ovr_d;

  always_comb begin
    acc    = classify(wr, rd);
    full_d = full;
    ovr_d  = 1'b0;
    unique case (acc)
      ACC_IDLE:  full_d = full;
      ACC_WRITE: begin full_d = 1'b1; ovr_d = full; end
      ACC_READ:  full_d = 1'b0;
      ACC_BOTH:  full_d = 1'b1;   // read consumes old word, write refills
      default:   full_d = full;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      full    <= full_d;
      overrun <= ovr_d;
    end
  end

  AST_WR_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> full) else $error("write flag"); // R2
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> !full) else $error("read clear"); // R4
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !wr) |=> $stable(full)) else $error("flag hold"); // R9
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> ($past(wr) && $past(full) && !$past(rd))) else $error("overrun cause"); // R7
  AST_OVR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !(wr && full && !rd)) |=> !overrun) else $error("overrun width"); // R7
endmodule

// File: rtl/drx_rdport.sv
module drx_rdport #(
  parameter int unsigned   DW   = 32,
  parameter logic [DW-1:0] FILL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          full,
  input  logic [DW-1:0] held,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd;
  end

  always_ff @(posedge clk) begin
    if (rd) rdata <= full ? held : FILL;
  end

  AST_RVALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid == ($past(rd) && $past(rst_n))) else $error("rvalid timing"); // R8
  AST_RDATA_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && full) |=> rdata == $past(held)) else $error("read data"); // R3
endmodule

// File: rtl/dbg_rx_mailbox.sv
module dbg_rx_mailbox #(
  parameter int unsigned   DW   = dbg_rx_pkg::DEF_DW,
  parameter logic [DW-1:0] FILL = {(DW/2){2'b10}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_wr_valid,
  output logic          dbg_wr_ready,
  input  logic [DW-1:0] dbg_wr_data,
  input  logic          cpu_rd_req,
  output logic          cpu_rd_valid,
  output logic [DW-1:0] cpu_rd_data,
  output logic          rx_full,
  output logic          wr_overrun
);
  logic          wr_fire;
  logic [DW-1:0] held;

  assign dbg_wr_ready = 1'b1;
  assign wr_fire      = dbg_wr_valid && dbg_wr_ready;

  drx_store #(.DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .load(wr_fire), .din(dbg_wr_data), .q(held)
  );

  drx_flag u_flag (
    .clk(clk), .rst_n(rst_n), .wr(wr_fire), .rd(cpu_rd_req),
    .full(rx_full), .overrun(wr_overrun)
  );

  drx_rdport #(.DW(DW), .FILL(FILL)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(cpu_rd_req), .full(rx_full), .held(held),
    .rvalid(cpu_rd_valid), .rdata(cpu_rd_data)
  );

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr_ready) else $error("ready"); // R2
  AST_BOTH_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && cpu_rd_req) |=> (rx_full && !wr_overrun)) else $error("both"); // R6
endmodule

// File: tb/sim_dbg_rx_mailbox.sv
module sim_dbg_rx_mailbox;
  localparam int DW = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wv = 1'b0;
  logic rq = 1'b0;
  logic [DW-1:0] wd = '0;
  logic wrdy, rv, full, ovr;
  logic [DW-1:0] rdat;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dbg_rx_mailbox #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .dbg_wr_valid(wv), .dbg_wr_ready(wrdy),
    .dbg_wr_data(wd), .cpu_rd_req(rq), .cpu_rd_valid(rv), .cpu_rd_data(rdat),
    .rx_full(full), .wr_overrun(ovr)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wv = 1'b0; rq = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic          mfull;
    logic [DW-1:0] mdata;
    logic [DW-1:0] edata;
    logic          ew, er;
    do_reset();
    // R1 reset state
    chk("R1 full", full, 0);
    chk("R1 rvalid", rv, 0);
    chk("R1 overrun", ovr, 0);
    chk("R2 ready", wrdy, 1);
    for (int s = 0; s < 256; s++) begin
      do_reset();
      chk("R1 full", full, 0);
      mfull = 1'b0; mdata = '0;
      for (int k = 0; k < 4; k++) begin
        ew = s[2*k];
        er = s[2*k+1];
        @(negedge clk);
        wv = ew; rq = er;
        wd = 32'h1357_0000 + s * 16 + k * 3 + 32'h0101;
        edata = mdata;
        @(posedge clk);
        #1;
        // expected outcome after this edge
        chk("R8 rvalid", rv, er);
        if (er && mfull) chk(ew ? "R6 old word" : "R3 data", rdat, edata);
        chk(ew ? (er ? "R6 flag" : "R2 flag") : (er ? (mfull ? "R4 flag" : "R5 flag") : "R9 hold"),
            full, ew | (mfull & ~er));
        chk("R7 overrun", ovr, ew & mfull & ~er);
        chk("R2 ready", wrdy, 1);
        mfull = ew | (mfull & ~er);
        if (ew) mdata = wd;
      end
      // drain: final read returns the last stored word if full (R6 new word)
      @(negedge clk);
      wv = 1'b0; rq = 1'b1;
      @(posedge clk); #1;
      chk("R8 rvalid", rv, 1);
      if (mfull) chk("R6 final word", rdat, mdata);
      chk("R4 flag", full, 0);
      @(negedge clk);
      rq = 1'b0;
      @(posedge clk); #1;
      chk("R8 rvalid low", rv, 0);
      chk("R7 no overrun", ovr, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule